// File: doc/BRIEF.md
# Block Write Protection Decoder

This block guards every write to a 32K x 8 non-volatile array and to the status register that holds its protection setting. Each cycle it may receive an array write request with a 15-bit byte address, a status write request carrying a new 3-bit protection select, and set or clear commands for the write enable latch. It compares the request against the current select field, the latch and a hardware lock input, then either issues a one-cycle write strobe or refuses the request with no side effect.

The select field protects nothing, a small region of 64-byte pages at the bottom of the array, the upper quarter or half, or the whole array. Any granted write clears the latch, so each write needs a fresh enable. Reset models power-up and power-down: the latch starts clear, so nothing can be written until an explicit enable arrives. All outputs are registered. A strobe appears on the clock edge after the request, and the latch and select change on that same edge.

Top module: `wp_guard`

## Requirements
- R1: After reset, `wel_q` is 0, `arr_strobe` and `stat_strobe` are 0, and `sel_q` equals the parameter `RESET_SEL` (default 0).
- R2: `wel_set` sets `wel_q` on the next edge. `wel_clear` clears it. When both are high, clear wins.
- R3: While `wel_q` is 0, an array or status request gives no strobe and leaves `wel_q` and `sel_q` unchanged.
- R4: The select codes map to protected address ranges: 0 protects none, 1 protects 0x0000-0x003F, 2 protects 0x0000-0x007F, 3 protects 0x0000-0x00FF, 4 protects 0x0000-0x01FF, 5 protects 0x6000-0x7FFF, 6 protects 0x4000-0x7FFF, and 7 protects every address. A request to a protected address gives no strobe and leaves `wel_q` set.
- R5: A permitted array request (`wel_q`=1, address outside the protected range, no status request in that cycle) raises `arr_strobe` for exactly one cycle on the next edge. On that edge `arr_addr_q` takes the request address and `wel_q` clears.
- R6: A status request with `wel_q`=1 and `hw_lock`=0 loads `stat_sel` into `sel_q` on the next edge. On that edge it also pulses `stat_strobe` and clears `wel_q`.
- R7: While `hw_lock` is 1, status requests are refused. No strobe is issued, and `sel_q` and `wel_q` keep their values.
- R8: An array request in the same cycle as a status request is always refused, even when the status request is also refused.
- R9: When a granted write and `wel_set` fall in the same cycle, `wel_q` ends up 0.
- R10: `arr_strobe` and `stat_strobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up/down) |
| hw_lock | input | 1 | Hardware lock; high refuses status writes |
| wel_set | input | 1 | Set write enable latch |
| wel_clear | input | 1 | Clear write enable latch |
| arr_req | input | 1 | Array write request |
| arr_addr | input | 15 | Byte address of array request |
| stat_req | input | 1 | Status write request |
| stat_sel | input | 3 | New protection select for status write |
| arr_strobe | output | 1 | One-cycle array write permit |
| arr_addr_q | output | 15 | Address of the last permitted array write |
| stat_strobe | output | 1 | One-cycle status write permit |
| wel_q | output | 1 | Write enable latch state |
| sel_q | output | 3 | Current protection select |

## Verification
Internal state here is only the latch and the select field, and both are outputs. A corrupted state therefore shows at `wel_q` or `sel_q` on the edge after the faulty update. A wrong region decode cannot be seen directly. It shows one edge after a request, either as a strobe on a protected address or as a missing strobe and a latch that stayed set on a free address. The vector walk therefore probes both sides of every region boundary.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    PS_NONE = 3'd0,
    PS_PG1  = 3'd1,
    PS_PG2  = 3'd2,
    PS_PG4  = 3'd3,
    PS_PG8  = 3'd4,
    PS_QTR  = 3'd5,
    PS_HALF = 3'd6,
    PS_ALL  = 3'd7
  } prot_sel_e;

  localparam int PAGE_CODES = 4;
endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [PAGE_CODES:1] page_hit;

  genvar k;
  generate
    for (k = 1; k <= PAGE_CODES; k++) begin : g_page
      localparam int SHIFT = PAGE_W + k - 1;
      logic [ADDR_W-1:0] upper;
      assign upper       = addr >> SHIFT;
      assign page_hit[k] = (upper == '0);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    unique case (prot_sel_e'(sel))
      PS_NONE: hit = 1'b0;
      PS_PG1:  hit = page_hit[1];
      PS_PG2:  hit = page_hit[2];
      PS_PG4:  hit = page_hit[3];
      PS_PG8:  hit = page_hit[4];
      PS_QTR:  hit = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
      PS_HALF: hit = addr[ADDR_W-1];
      PS_ALL:  hit = 1'b1;
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clear_i,
  input  logic consume_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (rst)                      wel_o <= 1'b0;
    else if (consume_i || clear_i) wel_o <= 1'b0;
    else if (set_i)               wel_o <= 1'b1;
  end
endmodule

// File: rtl/wp_select_reg.sv
module wp_select_reg
  import wp_pkg::*;
#(
  parameter logic [SEL_W-1:0] RESET_SEL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SEL_W-1:0] data_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk) begin
    if (rst)         sel_o <= RESET_SEL;
    else if (load_i) sel_o <= data_i;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int                ADDR_W     = 15,
  parameter int                PAGE_BYTES = 64,
  parameter logic [SEL_W-1:0]  RESET_SEL  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_lock,
  input  logic              wel_set,
  input  logic              wel_clear,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              stat_req,
  input  logic [SEL_W-1:0]  stat_sel,
  output logic              arr_strobe,
  output logic [ADDR_W-1:0] arr_addr_q,
  output logic              stat_strobe,
  output logic              wel_q,
  output logic [SEL_W-1:0]  sel_q
);
  logic region_hit;
  logic stat_ok;
  logic arr_ok;

  wp_region_decode #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_decode (
    .addr (arr_addr),
    .sel  (sel_q),
    .hit  (region_hit)
  );

  assign stat_ok = stat_req && wel_q && !hw_lock;
  assign arr_ok  = arr_req && !stat_req && wel_q && !region_hit;

  wp_enable_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .set_i     (wel_set),
    .clear_i   (wel_clear),
    .consume_i (stat_ok || arr_ok),
    .wel_o     (wel_q)
  );

  wp_select_reg #(.RESET_SEL(RESET_SEL)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .load_i (stat_ok),
    .data_i (stat_sel),
    .sel_o  (sel_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_strobe  <= 1'b0;
      stat_strobe <= 1'b0;
      arr_addr_q  <= '0;
    end else begin
      arr_strobe  <= arr_ok;
      stat_strobe <= stat_ok;
      if (arr_ok) arr_addr_q <= arr_addr;
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_lock,
  input logic              arr_req,
  input logic              stat_req,
  input logic              arr_strobe,
  input logic              stat_strobe,
  input logic              wel_q,
  input logic [2:0]        sel_q
);
  a_r10_onehot_strobes: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_strobe, stat_strobe}));

  a_r5_latch_clears_after_array: assert property (@(posedge clk) disable iff (rst)
    arr_strobe |-> !wel_q);

  a_r6_latch_clears_after_status: assert property (@(posedge clk) disable iff (rst)
    stat_strobe |-> !wel_q);

  a_r3_no_write_without_latch: assert property (@(posedge clk) disable iff (rst)
    (!wel_q && (arr_req || stat_req)) |=> !(arr_strobe || stat_strobe));

  a_r7_lock_freezes_select: assert property (@(posedge clk) disable iff (rst)
    hw_lock |=> ($stable(sel_q) && !stat_strobe));

  a_r8_status_beats_array: assert property (@(posedge clk) disable iff (rst)
    stat_req |=> !arr_strobe);

  a_r4_all_blocks_array: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 3'd7 && !stat_req) |=> !arr_strobe);
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hw_lock     (hw_lock),
  .arr_req     (arr_req),
  .stat_req    (stat_req),
  .arr_strobe  (arr_strobe),
  .stat_strobe (stat_strobe),
  .wel_q       (wel_q),
  .sel_q       (sel_q)
);

// File: tb/wp_guard_bench.sv
module wp_guard_bench;
  localparam int ADDR_W = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hw_lock = 1'b0;
  logic              wel_set = 1'b0;
  logic              wel_clear = 1'b0;
  logic              arr_req = 1'b0;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic              stat_req = 1'b0;
  logic [2:0]        stat_sel = '0;
  logic              arr_strobe;
  logic [ADDR_W-1:0] arr_addr_q;
  logic              stat_strobe;
  logic              wel_q;
  logic [2:0]        sel_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_guard u_wp_guard (
    .clk(clk), .rst(rst), .hw_lock(hw_lock), .wel_set(wel_set),
    .wel_clear(wel_clear), .arr_req(arr_req), .arr_addr(arr_addr),
    .stat_req(stat_req), .stat_sel(stat_sel), .arr_strobe(arr_strobe),
    .arr_addr_q(arr_addr_q), .stat_strobe(stat_strobe), .wel_q(wel_q),
    .sel_q(sel_q)
  );

  // {select, address, permitted}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 15'h0000, 1'b1}, {3'd0, 15'h7FFF, 1'b1},
    {3'd1, 15'h003F, 1'b0}, {3'd1, 15'h0040, 1'b1},
    {3'd2, 15'h007F, 1'b0}, {3'd2, 15'h0080, 1'b1},
    {3'd3, 15'h00FF, 1'b0}, {3'd3, 15'h0100, 1'b1},
    {3'd4, 15'h01FF, 1'b0}, {3'd4, 15'h0200, 1'b1},
    {3'd5, 15'h5FFF, 1'b1}, {3'd5, 15'h6000, 1'b0},
    {3'd6, 15'h3FFF, 1'b1}, {3'd6, 15'h4000, 1'b0},
    {3'd6, 15'h7FFF, 1'b0}, {3'd7, 15'h0000, 1'b0},
    {3'd7, 15'h4123, 1'b0}, {3'd7, 15'h7FFF, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a negedge, hold across one posedge, release at next negedge
  task automatic cyc(input bit s, input bit c, input bit ar,
                     input logic [ADDR_W-1:0] a, input bit sr, input logic [2:0] d);
    wel_set = s; wel_clear = c; arr_req = ar; arr_addr = a;
    stat_req = sr; stat_sel = d;
    @(negedge clk);
    wel_set = 0; wel_clear = 0; arr_req = 0; stat_req = 0;
  endtask

  task automatic set_sel(input logic [2:0] d);
    cyc(1, 0, 0, '0, 0, '0);
    cyc(0, 0, 0, '0, 1, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 wel", wel_q, 0);
    chk("R1 arr_strobe", arr_strobe, 0);
    chk("R1 stat_strobe", stat_strobe, 0);
    chk("R1 sel", sel_q, 0);

    // R4/R5 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vs;
      logic [ADDR_W-1:0] va;
      logic vok;
      {vs, va, vok} = VEC[i];
      set_sel(vs);
      chk("R6 sel load", sel_q, vs);
      chk("R6 stat_strobe", stat_strobe, 1);
      chk("R6 wel cleared", wel_q, 0);
      cyc(1, 0, 0, '0, 0, '0);
      cyc(0, 0, 1, va, 0, '0);
      chk("R4 R5 arr_strobe", arr_strobe, vok);
      chk("R4 R5 wel after", wel_q, !vok);
      if (vok) chk("R5 addr", arr_addr_q, va);
      if (vok) begin
        @(negedge clk);
        chk("R5 single cycle", arr_strobe, 0);
      end
      cyc(0, 1, 0, '0, 0, '0);
    end

    // R3: writes without latch
    set_sel(3'd0);
    cyc(0, 0, 1, 15'h0123, 0, '0);
    chk("R3 no arr strobe", arr_strobe, 0);
    chk("R3 wel stays", wel_q, 0);
    cyc(0, 0, 0, '0, 1, 3'd5);
    chk("R3 no stat strobe", stat_strobe, 0);
    chk("R3 sel kept", sel_q, 0);

    // R2: set, clear, both
    cyc(1, 0, 0, '0, 0, '0);
    chk("R2 set", wel_q, 1);
    cyc(0, 1, 0, '0, 0, '0);
    chk("R2 clear", wel_q, 0);
    cyc(1, 1, 0, '0, 0, '0);
    chk("R2 clear wins", wel_q, 0);

    // R7: hardware lock
    cyc(1, 0, 0, '0, 0, '0);
    hw_lock = 1;
    cyc(0, 0, 0, '0, 1, 3'd6);
    chk("R7 no stat strobe", stat_strobe, 0);
    chk("R7 sel frozen", sel_q, 0);
    chk("R7 wel kept", wel_q, 1);
    cyc(0, 0, 1, 15'h0200, 0, '0);
    chk("R7 array still allowed", arr_strobe, 1);
    hw_lock = 0;

    // R8: simultaneous requests
    cyc(1, 0, 0, '0, 0, '0);
    cyc(0, 0, 1, 15'h0300, 1, 3'd2);
    chk("R8 arr refused", arr_strobe, 0);
    chk("R8 stat granted", stat_strobe, 1);
    chk("R8 sel", sel_q, 2);
    set_sel(3'd0);
    hw_lock = 1;
    cyc(1, 0, 0, '0, 0, '0);
    cyc(0, 0, 1, 15'h0300, 1, 3'd3);
    chk("R8 arr refused with locked stat", arr_strobe, 0);
    chk("R8 wel kept", wel_q, 1);
    hw_lock = 0;

    // R9: set in same cycle as granted write
    cyc(1, 1, 1, 15'h0010, 0, '0);
    cyc(1, 0, 0, '0, 0, '0);
    cyc(1, 0, 1, 15'h0010, 0, '0);
    chk("R9 strobe", arr_strobe, 1);
    chk("R9 wel zero", wel_q, 0);

    // R1: reset mid-run clears latch
    cyc(1, 0, 0, '0, 0, '0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 reset clears wel", wel_q, 0);
    chk("R1 reset clears sel", sel_q, 0);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule